// File: doc/BRIEF.md
# Serial Port Buffer Status and Interrupt Controller

This block watches the receive and transmit byte queues of a serial port from the outside. It never holds the bytes. It reads the occupancy counts of both queues and the push and pop strobes. It also takes a character-time tick, the receive error and break pulses, the clear-to-send input and a set of programmable levels. From these it derives the request-to-send output, the queue level indications, a one-byte-left indication for transmit and an idle timeout for receive.

Every event is caught in a ten-bit sticky flag vector. Software clears a flag by writing a one to its bit. The flag vector is masked bit by bit with an enable vector, and the masked bits are combined into one interrupt line. The block also produces the queue flush requests. These come from the two flush control bits, and from the port enable when it is low.

Top module: `sio_status_irq`

## Requirements
- R1: Flag bit 4 is set on the cycle where the condition "receive threshold is nonzero and rx_count is at least the receive threshold" changes from false to true. rx_lvl_o shows that condition one clock after the inputs change.
- R2: Flag bit 6 is set on the cycle where the condition "transmit threshold is nonzero and tx_count is at least the transmit threshold" changes from false to true. tx_lvl_o shows that condition one clock after the inputs change.
- R3: rts_o is high (peer may send) one clock after rx_count is below rts_thr, and low one clock after rx_count is at or above rts_thr. rts_o is low while reset is held.
- R4: Flag bit 5 is set on the clock where tx_count becomes exactly 1.
- R5: While rx_count is nonzero and no push or pop occurs, flag bit 8 is set on the idle_limit-th char_tick. The count restarts on a push, on a pop, or when the queue is empty. The flag fires once per idle period, and an idle_limit of 0 disables it.
- R6: The flag positions are: frame error 0, parity error 1, clear-to-send change 2, overrun 3, receive level 4, one byte left 5, transmit level 6, break 7, receive idle 8, last break 9. A one-cycle event pulse sets its bit at the next clock.
- R7: A one in flag_clr clears that flag at the next clock and leaves the other flags unchanged. A set event in the same cycle wins over the clear.
- R8: A level flag (bit 4 or bit 6) that has been cleared stays clear while its comparison remains true.
- R9: irq is high exactly when some flag bit and its irq_en bit are both one. It follows irq_en without a clock delay.
- R10: rx_flush_req is high one clock after rx_flush_bit is high or port_en is low. tx_flush_req is high one clock after tx_flush_bit is high or port_en is low.
- R11: A change of cts_in between two clocks sets flag bit 2. The value of cts_in on the first clock after reset never sets the flag.
- R12: While reset is held, flags, irq, rts_o, rx_lvl_o, tx_lvl_o and both flush requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low requests both flushes |
| tx_flush_bit | input | 1 | Transmit queue flush control |
| rx_flush_bit | input | 1 | Receive queue flush control |
| rx_count | input | CW | Receive queue occupancy |
| tx_count | input | CW | Transmit queue occupancy |
| rx_push | input | 1 | Byte written into receive queue |
| rx_pop | input | 1 | Byte read from receive queue |
| char_tick | input | 1 | One pulse per character time |
| rx_frame_err | input | 1 | Frame error event |
| rx_parity_err | input | 1 | Parity error event |
| rx_overrun | input | 1 | Receive overrun event |
| rx_break | input | 1 | Break received event |
| rx_last_break | input | 1 | Last break event |
| cts_in | input | 1 | Clear-to-send input, synchronous |
| rx_thr | input | CW | Receive level threshold, 0 disables |
| tx_thr | input | CW | Transmit level threshold, 0 disables |
| rts_thr | input | CW | Receive level at which rts_o drops |
| idle_limit | input | TW | Idle timeout in character times, 0 disables |
| irq_en | input | 10 | Per-flag interrupt enable |
| flag_clr | input | 10 | Write-one-to-clear strobe per flag |
| flags | output | 10 | Sticky flag vector |
| irq | output | 1 | Masked interrupt |
| rts_o | output | 1 | Request-to-send, high means ready |
| rx_lvl_o | output | 1 | Receive level condition |
| tx_lvl_o | output | 1 | Transmit level condition |
| tx_flush_req | output | 1 | Transmit queue flush request |
| rx_flush_req | output | 1 | Receive queue flush request |

## Verification
The assertions assume that every input is synchronous to clk, that the event inputs are pulses, and that rx_count changes only together with the push and pop strobes it reflects. They also assume that a queue count never exceeds the queue depth. The stimulus drives every input on the falling edge and raises each event for exactly one cycle. The counts it drives stay within the six-bit range. It changes idle_limit only while the receive queue is empty, so the idle counter is never left above a newly written limit.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;
  localparam int NFLAG = 10;

  // flag positions, fixed because software decodes them
  localparam int FI_FRAME  = 0;
  localparam int FI_PARITY = 1;
  localparam int FI_CTS    = 2;
  localparam int FI_OVR    = 3;
  localparam int FI_RXLVL  = 4;
  localparam int FI_TXONE  = 5;
  localparam int FI_TXLVL  = 6;
  localparam int FI_BRK    = 7;
  localparam int FI_RXIDLE = 8;
  localparam int FI_LBRK   = 9;

  typedef logic [NFLAG-1:0] flag_vec_t;

  typedef enum logic {CMP_GE_NZ = 1'b0, CMP_EQ = 1'b1} cmp_mode_e;
endpackage

// File: rtl/sio_lvl_edge.sv
module sio_lvl_edge
  import sio_status_pkg::*;
#(
  parameter int        W    = 6,
  parameter cmp_mode_e MODE = CMP_GE_NZ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic [W-1:0] thr,
  output logic         lvl_q,
  output logic         rise
);
  logic cmp;

  generate
    if (MODE == CMP_GE_NZ) begin : g_ge
      assign cmp = (thr != '0) && (count >= thr);
    end else begin : g_eq
      assign cmp = (count == thr);
    end
  endgenerate

  assign rise = cmp & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= cmp;
  end
endmodule

// File: rtl/sio_idle_timer.sv
module sio_idle_timer #(
  parameter int CW = 6,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          push,
  input  logic          pop,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          fire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          restart;
  logic [TW-1:0] cnt_inc;

  assign restart = push | pop | (count == '0);
  assign cnt_inc = cnt_q + TW'(1);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    fire   = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q && (limit != '0)) begin
      if (cnt_inc == limit) begin
        fire   = 1'b1;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags_q,
  output logic         irq
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = (flags_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign irq = |(flags_q & en);

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((flags_q & $past(clr & ~set)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags_q & $past(set)) == $past(set)));
endmodule

// File: rtl/sio_flush_ctl.sv
module sio_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic tx_bit,
  input  logic rx_bit,
  output logic tx_req,
  output logic rx_req
);
  logic tx_d, rx_d;

  always_comb begin
    tx_d = tx_bit | ~port_en;
    rx_d = rx_bit | ~port_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      tx_req <= tx_d;
      rx_req <= rx_d;
    end
  end

  // R10
  flush_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (tx_req && rx_req));
endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq
  import sio_status_pkg::*;
#(
  parameter int CW = 6,
  parameter int TW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             tx_flush_bit,
  input  logic             rx_flush_bit,
  input  logic [CW-1:0]    rx_count,
  input  logic [CW-1:0]    tx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             rx_frame_err,
  input  logic             rx_parity_err,
  input  logic             rx_overrun,
  input  logic             rx_break,
  input  logic             rx_last_break,
  input  logic             cts_in,
  input  logic [CW-1:0]    rx_thr,
  input  logic [CW-1:0]    tx_thr,
  input  logic [CW-1:0]    rts_thr,
  input  logic [TW-1:0]    idle_limit,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             rts_o,
  output logic             rx_lvl_o,
  output logic             tx_lvl_o,
  output logic             tx_flush_req,
  output logic             rx_flush_req
);
  localparam logic [CW-1:0] ONE_LEFT = CW'(1);

  logic      rx_lvl_rise, tx_lvl_rise, tx_one_rise, tx_one_q;
  logic      idle_fire;
  logic      cts_q, cts_vld_q, cts_chg;
  logic      rts_d;
  flag_vec_t set_vec;

  // clear-to-send change detect, first clock after reset only primes
  always_comb cts_chg = cts_vld_q & (cts_in ^ cts_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q     <= 1'b0;
      cts_vld_q <= 1'b0;
    end else begin
      cts_q     <= cts_in;
      cts_vld_q <= 1'b1;
    end
  end

  // request-to-send, high while the receive queue is below its stop level
  always_comb rts_d = (rx_count < rts_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_o <= 1'b0;
    else        rts_o <= rts_d;
  end

  sio_lvl_edge #(.W(CW), .MODE(CMP_GE_NZ)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .thr(rx_thr),
    .lvl_q(rx_lvl_o), .rise(rx_lvl_rise));

  sio_lvl_edge #(.W(CW), .MODE(CMP_GE_NZ)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .thr(tx_thr),
    .lvl_q(tx_lvl_o), .rise(tx_lvl_rise));

  sio_lvl_edge #(.W(CW), .MODE(CMP_EQ)) u_tx_one (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .thr(ONE_LEFT),
    .lvl_q(tx_one_q), .rise(tx_one_rise));

  sio_idle_timer #(.CW(CW), .TW(TW)) u_idle (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .push(rx_push),
    .pop(rx_pop), .tick(char_tick), .limit(idle_limit), .fire(idle_fire));

  always_comb begin
    set_vec            = '0;
    set_vec[FI_FRAME]  = rx_frame_err;
    set_vec[FI_PARITY] = rx_parity_err;
    set_vec[FI_CTS]    = cts_chg;
    set_vec[FI_OVR]    = rx_overrun;
    set_vec[FI_RXLVL]  = rx_lvl_rise;
    set_vec[FI_TXONE]  = tx_one_rise;
    set_vec[FI_TXLVL]  = tx_lvl_rise;
    set_vec[FI_BRK]    = rx_break;
    set_vec[FI_RXIDLE] = idle_fire;
    set_vec[FI_LBRK]   = rx_last_break;
  end

  sio_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(flag_clr),
    .en(irq_en), .flags_q(flags), .irq(irq));

  sio_flush_ctl u_flush (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .tx_bit(tx_flush_bit), .rx_bit(rx_flush_bit),
    .tx_req(tx_flush_req), .rx_req(rx_flush_req));

  // R1
  rx_lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lvl_o) |-> flags[FI_RXLVL]);

  // R4
  tx_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_one_q) |-> flags[FI_TXONE]);

  // R3
  rts_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= rts_thr) |=> !rts_o);

  // R5
  idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FI_RXIDLE]) |-> $past(rx_count != '0));
endmodule

// File: tb/sio_status_irq_tb.sv
module sio_status_irq_tb;
  localparam int CW = 6;
  localparam int TW = 8;
  localparam int NF = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic port_en, tx_flush_bit, rx_flush_bit;
  logic [CW-1:0] rx_count, tx_count, rx_thr, tx_thr, rts_thr;
  logic rx_push, rx_pop, char_tick;
  logic rx_frame_err, rx_parity_err, rx_overrun, rx_break, rx_last_break;
  logic cts_in;
  logic [TW-1:0] idle_limit;
  logic [NF-1:0] irq_en, flag_clr, flags;
  logic irq, rts_o, rx_lvl_o, tx_lvl_o, tx_flush_req, rx_flush_req;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sio_status_irq #(.CW(CW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .tx_flush_bit(tx_flush_bit), .rx_flush_bit(rx_flush_bit),
    .rx_count(rx_count), .tx_count(tx_count), .rx_push(rx_push),
    .rx_pop(rx_pop), .char_tick(char_tick), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun),
    .rx_break(rx_break), .rx_last_break(rx_last_break), .cts_in(cts_in),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .rts_thr(rts_thr),
    .idle_limit(idle_limit), .irq_en(irq_en), .flag_clr(flag_clr),
    .flags(flags), .irq(irq), .rts_o(rts_o), .rx_lvl_o(rx_lvl_o),
    .tx_lvl_o(tx_lvl_o), .tx_flush_req(tx_flush_req),
    .rx_flush_req(rx_flush_req));

  // {rx_count, rx_thr, rts_thr, expected rx_lvl_o, expected rts_o}
  localparam int NV = 8;
  localparam logic [19:0] TV [NV] = '{
    {6'd0,  6'd4,  6'd8,  1'b0, 1'b1},
    {6'd3,  6'd4,  6'd8,  1'b0, 1'b1},
    {6'd4,  6'd4,  6'd8,  1'b1, 1'b1},
    {6'd7,  6'd4,  6'd8,  1'b1, 1'b1},
    {6'd8,  6'd4,  6'd8,  1'b1, 1'b0},
    {6'd20, 6'd4,  6'd8,  1'b1, 1'b0},
    {6'd5,  6'd0,  6'd32, 1'b0, 1'b1},
    {6'd32, 6'd32, 6'd32, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = '1;
    step();
    flag_clr = '0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1;
      step();
      char_tick = 1'b0;
      step();
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; port_en = 1'b0; tx_flush_bit = 1'b0; rx_flush_bit = 1'b0;
    rx_count = '0; tx_count = '0; rx_thr = '0; tx_thr = '0; rts_thr = 6'd8;
    rx_push = 1'b0; rx_pop = 1'b0; char_tick = 1'b0;
    rx_frame_err = 1'b0; rx_parity_err = 1'b0; rx_overrun = 1'b0;
    rx_break = 1'b0; rx_last_break = 1'b0; cts_in = 1'b1;
    idle_limit = '0; irq_en = '0; flag_clr = '0;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 flags", 32'(flags), 0);
    chk("R12 irq/rts/lvl/flush",
        {26'd0, irq, rts_o, rx_lvl_o, tx_lvl_o, tx_flush_req, rx_flush_req}, 0);

    rst_n = 1'b1; port_en = 1'b1;
    step(); step();
    // R11 no change flag from the first sample of cts_in after reset
    chk("R11 no spurious cts flag", 32'(flags), 0);
    chk("R3 rts high below level", 32'(rts_o), 1);
    chk("R10 no flush when enabled", {tx_flush_req, rx_flush_req}, 0);

    // R1 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      rx_count = TV[v][19:14];
      rx_thr   = TV[v][13:8];
      rts_thr  = TV[v][7:2];
      step();
      chk($sformatf("R1 rx_lvl_o vec%0d", v), 32'(rx_lvl_o), 32'(TV[v][1]));
      chk($sformatf("R3 rts_o vec%0d", v), 32'(rts_o), 32'(TV[v][0]));
    end
    rx_count = '0; rx_thr = '0; rts_thr = 6'd8;
    step();
    clear_all();
    chk("R7 clear all", 32'(flags), 0);

    // R6 event bit positions
    rx_frame_err = 1'b1; step(); rx_frame_err = 1'b0;
    chk("R6 frame bit0", 32'(flags), 32'h001); clear_all();
    rx_parity_err = 1'b1; step(); rx_parity_err = 1'b0;
    chk("R6 parity bit1", 32'(flags), 32'h002); clear_all();
    rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
    chk("R6 overrun bit3", 32'(flags), 32'h008); clear_all();
    rx_break = 1'b1; step(); rx_break = 1'b0;
    chk("R6 break bit7", 32'(flags), 32'h080); clear_all();
    rx_last_break = 1'b1; step(); rx_last_break = 1'b0;
    chk("R6 last break bit9", 32'(flags), 32'h200); clear_all();

    // R9 masking
    rx_frame_err = 1'b1; step(); rx_frame_err = 1'b0;
    chk("R9 irq masked", 32'(irq), 0);
    irq_en = 10'h001; #1;
    chk("R9 irq enabled", 32'(irq), 1);
    irq_en = 10'h3FE; #1;
    chk("R9 irq other enables", 32'(irq), 0);
    irq_en = 10'h001;
    clear_all();
    chk("R9 irq after clear", 32'(irq), 0);
    irq_en = '0;

    // R7 set wins, selective clear
    rx_parity_err = 1'b1; flag_clr = 10'h002; step();
    rx_parity_err = 1'b0; flag_clr = '0;
    chk("R7 set wins over clear", 32'(flags), 32'h002);
    rx_frame_err = 1'b1; step(); rx_frame_err = 1'b0;
    flag_clr = 10'h001; step(); flag_clr = '0;
    chk("R7 clear one keeps other", 32'(flags), 32'h002);
    clear_all();

    // R11 clear-to-send change
    cts_in = 1'b0; step();
    chk("R11 cts change bit2", 32'(flags), 32'h004);
    clear_all(); step();
    chk("R11 steady cts no flag", 32'(flags), 0);

    // R1 / R8 receive level edge
    rx_thr = 6'd4; rx_count = 6'd5; step();
    chk("R1 rx level flag bit4", 32'(flags), 32'h010);
    flag_clr = 10'h010; step(); flag_clr = '0;
    step(); step();
    chk("R8 cleared level flag stays clear", 32'(flags), 0);
    rx_count = 6'd2; step();
    chk("R1 rx_lvl_o low", 32'(rx_lvl_o), 0);
    rx_count = 6'd4; step();
    chk("R1 rx level re-arm", 32'(flags), 32'h010);
    rx_count = '0; rx_thr = '0; step();
    clear_all();

    // R2 / R4 transmit level and one byte left
    tx_thr = 6'd3; tx_count = 6'd3; step();
    chk("R2 tx level flag bit6", 32'(flags), 32'h040);
    chk("R2 tx_lvl_o", 32'(tx_lvl_o), 1);
    clear_all();
    tx_count = 6'd2; step();
    chk("R4 two left no flag", 32'(flags), 0);
    tx_count = 6'd1; step();
    chk("R4 one left bit5", 32'(flags), 32'h020);
    tx_count = '0; tx_thr = '0; step();
    clear_all();

    // R5 receive idle timeout
    idle_limit = 8'd3;
    rx_count = 6'd2; rx_push = 1'b1; step(); rx_push = 1'b0;
    tick(2);
    chk("R5 idle before limit", 32'(flags), 0);
    tick(1);
    chk("R5 idle at limit bit8", 32'(flags), 32'h100);
    clear_all();
    tick(4);
    chk("R5 idle fires once", 32'(flags), 0);
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    tick(2);
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    tick(2);
    chk("R5 pop restarts count", 32'(flags), 0);
    tick(1);
    chk("R5 idle after restart", 32'(flags), 32'h100);
    clear_all();
    rx_count = '0; step();
    idle_limit = '0;
    rx_count = 6'd1; step();
    tick(5);
    chk("R5 limit zero disables", 32'(flags), 0);
    rx_count = '0; step();

    // R10 flush requests
    rx_flush_bit = 1'b1; step();
    chk("R10 rx flush bit", {tx_flush_req, rx_flush_req}, 32'h1);
    rx_flush_bit = 1'b0; tx_flush_bit = 1'b1; step();
    chk("R10 tx flush bit", {tx_flush_req, rx_flush_req}, 32'h2);
    tx_flush_bit = 1'b0; port_en = 1'b0; step();
    chk("R10 disable flushes both", {tx_flush_req, rx_flush_req}, 32'h3);
    port_en = 1'b1; step();
    chk("R10 enabled no flush", {tx_flush_req, rx_flush_req}, 0);

    finish_up();
  end
endmodule